// File: doc/BRIEF.md
# Channel and Die Address Dehasher

This block reverses an interleave hash that a memory fabric applies to a 64-bit system address. When a fabric spreads traffic across channels and dies, it XORs selected high address bits into the low bits that pick the channel and the die. To recover the address the fabric actually used, each select bit has to be XORed again with the same set of high bits. The block corrects up to five channel-select bits first, then up to two die-select bits. Each correction works on the address as changed by the corrections before it.

Five hash enables switch groups of terms on or off. The groups follow the granule the term comes from: 4 KiB, 64 KiB, 2 MiB, 1 GiB and 1 TiB. The caller also supplies the channel interleave count, the die interleave count, the socket count and the interleave bit position, together with a valid strobe. One cycle later the block returns the corrected address and an error flag. If the mapping parameters are not a supported combination, the flag is raised and the address passes through unchanged.

Top module: `addr_dehash`

## Requirements
- R1: The number of channel bits corrected is 3, 4 or 5 for a channel count of 8, 16 or 32. Channel bit i (i = 0..4) sits at address position 8+i, except bit 4, which sits at position 14.
- R2: With hash enable bit 0 (4 KiB) set, channel bit i takes address bit 12+i as a term, but only for i = 0, 1 and 2.
- R3: Channel bit i takes address bit 15+i under enable bit 1 (64 KiB), bit 22+i under enable bit 2 (2 MiB) and bit 29+i under enable bit 3 (1 GiB).
- R4: Under enable bit 4 (1 TiB), channel bit i takes two terms: address bits 36+i and 43+i.
- R5: The number of die bits is 0, 1, 1 or 2 for a die count of 1, 2, 3 or 4. Die bit i sits at position 12+i and takes bit 20+i (enable bit 1), bit 27+i (enable bit 2), bit 34+i (enable bit 3) and bit 41+i (enable bit 4).
- R6: All channel bits are corrected before any die bit, in increasing i. Every term is read from the address as already updated by the earlier corrections.
- R7: A select bit is inverted only when the XOR of its enabled terms is 1. No address bit outside positions 8..14 ever changes, and with all enables clear the address is returned unchanged.
- R8: The error flag is raised and the input address is returned unchanged in any of these cases: the interleave bit position is not 8, the die count is 0 or greater than 4, or the socket count is not 1.
- R9: A channel count other than 8, 16 or 32 raises the error flag and returns the input address unchanged.
- R10: Results appear one clock after a cycle with validIn high, with outValid high. In a cycle after validIn low, outValid is low and outAddr and outErr keep their values. Reset clears outAddr, outErr and outValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Request strobe |
| inAddr | input | 64 | Hashed address |
| hashEn | input | 5 | Hash enables: bit0 4 KiB, bit1 64 KiB, bit2 2 MiB, bit3 1 GiB, bit4 1 TiB |
| chanCount | input | 6 | Channel interleave count |
| dieCount | input | 3 | Die interleave count |
| sockCount | input | 3 | Socket interleave count |
| intlvPos | input | 6 | Interleave bit position |
| outAddr | output | 64 | Dehashed address |
| outErr | output | 1 | Unsupported mapping parameters |
| outValid | output | 1 | Result strobe |

## Verification
Single-enable cases with one high bit set show whether every term is tied to the right select bit. They also show that the 4 KiB term stops after the third channel bit and that the 1 TiB enable drives two terms. Dense random addresses under every channel count and die count are compared with a bench model, which exposes any wrong base position, including the jump to position 14. A directed address where a die term and a channel term both touch bit 12 tells apart the two possible orders of the corrections. Out-of-range counts, socket counts and bit positions confirm the error flag and the unchanged pass-through.

// File: rtl/addr_dehash_pkg.sv
package addr_dehash_pkg;

  localparam int CHAN_BITS_MAX = 5;
  localparam int DIE_BITS_MAX  = 2;
  localparam int HASH_W        = 5;

  // hash enable indices
  localparam int EN_4K  = 0;
  localparam int EN_64K = 1;
  localparam int EN_2M  = 2;
  localparam int EN_1G  = 3;
  localparam int EN_1T  = 4;

  // term offsets for channel bits
  localparam int CH_4K_OFS  = 12;
  localparam int CH_64K_OFS = 15;
  localparam int CH_2M_OFS  = 22;
  localparam int CH_1G_OFS  = 29;
  localparam int CH_1TA_OFS = 36;
  localparam int CH_1TB_OFS = 43;
  localparam int CH_4K_LAST = 2;
  localparam int CH_BASE    = 8;
  localparam int CH_JUMP_I  = 4;
  localparam int CH_JUMP_POS = 14;

  // term offsets for die bits
  localparam int DIE_BASE    = 12;
  localparam int DIE_64K_OFS = 20;
  localparam int DIE_2M_OFS  = 27;
  localparam int DIE_1G_OFS  = 34;
  localparam int DIE_1T_OFS  = 41;

  localparam int REQ_POS  = 8;
  localparam int MIN_ADDR_W = 48;

  // span of positions that may ever be corrected
  localparam int FIX_LO = 8;
  localparam int FIX_HI = 14;

  typedef struct packed {
    logic [CHAN_BITS_MAX-1:0] chanEn;
    logic [DIE_BITS_MAX-1:0]  dieEn;
    logic                     fault;
  } dehash_strobes_t;

  function automatic int chanBasePos(input int i);
    return (i == CH_JUMP_I) ? CH_JUMP_POS : CH_BASE + i;
  endfunction

endpackage

// File: rtl/dehash_ctrl.sv
module dehash_ctrl
  import addr_dehash_pkg::*;
#(
  parameter int CHAN_CNT_W = 6,
  parameter int DIE_CNT_W  = 3,
  parameter int SOCK_W     = 3,
  parameter int POS_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CHAN_CNT_W-1:0] chanCount,
  input  logic [DIE_CNT_W-1:0]  dieCount,
  input  logic [SOCK_W-1:0]     sockCount,
  input  logic [POS_W-1:0]      intlvPos,
  output dehash_strobes_t       strb
);

  logic [CHAN_BITS_MAX-1:0] chanMask;
  logic                     chanBad;
  logic [DIE_BITS_MAX-1:0]  dieMask;
  logic                     dieBad;
  logic                     posBad;
  logic                     sockBad;

  // channel count -> contiguous enable mask
  always_comb begin
    chanBad  = 1'b0;
    chanMask = '0;
    case (chanCount)
      CHAN_CNT_W'(8):  chanMask = 5'b00111;
      CHAN_CNT_W'(16): chanMask = 5'b01111;
      CHAN_CNT_W'(32): chanMask = 5'b11111;
      default:         chanBad  = 1'b1;
    endcase
  end

  // die count -> floor(log2) bits
  always_comb begin
    dieBad  = 1'b0;
    dieMask = '0;
    case (dieCount)
      DIE_CNT_W'(1): dieMask = 2'b00;
      DIE_CNT_W'(2): dieMask = 2'b01;
      DIE_CNT_W'(3): dieMask = 2'b01;
      DIE_CNT_W'(4): dieMask = 2'b11;
      default:       dieBad  = 1'b1;
    endcase
  end

  assign posBad  = (intlvPos != POS_W'(REQ_POS));
  assign sockBad = (sockCount != SOCK_W'(1));

  always_comb begin
    strb.fault  = chanBad | dieBad | posBad | sockBad;
    strb.chanEn = strb.fault ? '0 : chanMask;
    strb.dieEn  = strb.fault ? '0 : dieMask;
  end

  // R1: a legal mapping always corrects at least the three low channel bits
  assert_chan_floor_R1: assert property (@(posedge clk) disable iff (rst)
    !strb.fault |-> (strb.chanEn[2:0] == 3'b111));

  // R5: a second die bit never enabled without the first
  assert_die_order_R5: assert property (@(posedge clk) disable iff (rst)
    strb.dieEn[1] |-> strb.dieEn[0]);

endmodule

// File: rtl/dehash_datapath.sv
module dehash_datapath
  import addr_dehash_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               validIn,
  input  logic [ADDR_W-1:0]  inAddr,
  input  logic [HASH_W-1:0]  hashEn,
  input  dehash_strobes_t    strb,
  output logic [ADDR_W-1:0]  outAddr,
  output logic               outErr,
  output logic               outValid
);

  localparam logic [ADDR_W-1:0] FIX_MASK =
    ((ADDR_W'(1) << (FIX_HI + 1)) - ADDR_W'(1)) & ~((ADDR_W'(1) << FIX_LO) - ADDR_W'(1));

  logic [CHAN_BITS_MAX:0][ADDR_W-1:0] chanStage;
  logic [DIE_BITS_MAX:0][ADDR_W-1:0]  dieStage;

  assign chanStage[0] = inAddr;

  // channel corrections, strictly in increasing order
  for (genvar gi = 0; gi < CHAN_BITS_MAX; gi++) begin : g_chan
    localparam int BASE   = chanBasePos(gi);
    localparam bit HAS4K  = (gi <= CH_4K_LAST);
    logic parity;
    logic [ADDR_W-1:0] cur;
    assign cur = chanStage[gi];
    assign parity = (HAS4K & hashEn[EN_4K] & cur[CH_4K_OFS + gi])
                  ^ (hashEn[EN_64K] & cur[CH_64K_OFS + gi])
                  ^ (hashEn[EN_2M]  & cur[CH_2M_OFS + gi])
                  ^ (hashEn[EN_1G]  & cur[CH_1G_OFS + gi])
                  ^ (hashEn[EN_1T]  & (cur[CH_1TA_OFS + gi] ^ cur[CH_1TB_OFS + gi]));
    assign chanStage[gi+1] = (strb.chanEn[gi] & parity) ? (cur ^ (ADDR_W'(1) << BASE)) : cur;
  end

  assign dieStage[0] = chanStage[CHAN_BITS_MAX];

  // die corrections follow all channel corrections
  for (genvar gd = 0; gd < DIE_BITS_MAX; gd++) begin : g_die
    localparam int BASE = DIE_BASE + gd;
    logic parity;
    logic [ADDR_W-1:0] cur;
    assign cur = dieStage[gd];
    assign parity = (hashEn[EN_64K] & cur[DIE_64K_OFS + gd])
                  ^ (hashEn[EN_2M]  & cur[DIE_2M_OFS + gd])
                  ^ (hashEn[EN_1G]  & cur[DIE_1G_OFS + gd])
                  ^ (hashEn[EN_1T]  & cur[DIE_1T_OFS + gd]);
    assign dieStage[gd+1] = (strb.dieEn[gd] & parity) ? (cur ^ (ADDR_W'(1) << BASE)) : cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outAddr  <= '0;
      outErr   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= validIn;
      if (validIn) begin
        outErr  <= strb.fault;
        outAddr <= strb.fault ? inAddr : dieStage[DIE_BITS_MAX];
      end
    end
  end

  // R7: only the select window may differ from the request
  assert_window_only_R7: assert property (@(posedge clk) disable iff (rst)
    validIn |=> (((outAddr ^ $past(inAddr)) & ~FIX_MASK) == '0));

  // R7: with every enable clear nothing changes
  assert_no_enable_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (validIn && hashEn == '0) |=> (outAddr == $past(inAddr)));

  // R10: result strobe follows the request by one cycle
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    validIn |=> outValid);

  // R10: idle cycles keep the last result
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> (!outValid && $stable(outAddr) && $stable(outErr)));

endmodule

// File: rtl/addr_dehash.sv
module addr_dehash
  import addr_dehash_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int CHAN_CNT_W = 6,
  parameter int DIE_CNT_W  = 3,
  parameter int SOCK_W     = 3,
  parameter int POS_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  validIn,
  input  logic [ADDR_W-1:0]     inAddr,
  input  logic [HASH_W-1:0]     hashEn,
  input  logic [CHAN_CNT_W-1:0] chanCount,
  input  logic [DIE_CNT_W-1:0]  dieCount,
  input  logic [SOCK_W-1:0]     sockCount,
  input  logic [POS_W-1:0]      intlvPos,
  output logic [ADDR_W-1:0]     outAddr,
  output logic                  outErr,
  output logic                  outValid
);

  dehash_strobes_t strb;

  dehash_ctrl #(
    .CHAN_CNT_W(CHAN_CNT_W),
    .DIE_CNT_W (DIE_CNT_W),
    .SOCK_W    (SOCK_W),
    .POS_W     (POS_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .chanCount(chanCount),
    .dieCount (dieCount),
    .sockCount(sockCount),
    .intlvPos (intlvPos),
    .strb     (strb)
  );

  dehash_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .validIn (validIn),
    .inAddr  (inAddr),
    .hashEn  (hashEn),
    .strb    (strb),
    .outAddr (outAddr),
    .outErr  (outErr),
    .outValid(outValid)
  );

  // R8: a wrong interleave position yields an error and a pass-through
  assert_bad_pos_R8: assert property (@(posedge clk) disable iff (rst)
    (validIn && intlvPos != POS_W'(REQ_POS)) |=> (outErr && outAddr == $past(inAddr)));

  // R9: unsupported channel counts are flagged
  assert_bad_chan_R9: assert property (@(posedge clk) disable iff (rst)
    (validIn && chanCount != CHAN_CNT_W'(8) && chanCount != CHAN_CNT_W'(16)
     && chanCount != CHAN_CNT_W'(32)) |=> (outErr && outAddr == $past(inAddr)));

endmodule

// File: tb/addr_dehash_tb.sv
module addr_dehash_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [63:0] inAddr = '0;
  logic [4:0]  hashEn = '0;
  logic [5:0]  chanCount = 6'd8;
  logic [2:0]  dieCount = 3'd1;
  logic [2:0]  sockCount = 3'd1;
  logic [5:0]  intlvPos = 6'd8;
  logic [63:0] outAddr;
  logic        outErr;
  logic        outValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_dehash u_dut (
    .clk(clk), .rst(rst), .validIn(validIn), .inAddr(inAddr), .hashEn(hashEn),
    .chanCount(chanCount), .dieCount(dieCount), .sockCount(sockCount),
    .intlvPos(intlvPos), .outAddr(outAddr), .outErr(outErr), .outValid(outValid)
  );

  // bench model built from the requirements; returns {err, addr}
  function automatic logic [64:0] model(input logic [63:0] a, input logic [4:0] en,
                                         input logic [5:0] cc, input logic [2:0] dc,
                                         input logic [2:0] sc, input logic [5:0] pos);
    int nC;
    int nD;
    logic bad;
    logic [63:0] r;
    bad = 1'b0;
    r = a;
    case (cc)
      6'd8: nC = 3;
      6'd16: nC = 4;
      6'd32: nC = 5;
      default: begin nC = 0; bad = 1'b1; end
    endcase
    case (dc)
      3'd1: nD = 0;
      3'd2, 3'd3: nD = 1;
      3'd4: nD = 2;
      default: begin nD = 0; bad = 1'b1; end
    endcase
    if (sc != 3'd1 || pos != 6'd8) bad = 1'b1;
    if (bad) return {1'b1, a};
    for (int i = 0; i < nC; i++) begin
      int b;
      logic p;
      b = (i == 4) ? 14 : 8 + i;
      p = 1'b0;
      if (en[0] && i <= 2) p ^= r[12+i];
      if (en[1]) p ^= r[15+i];
      if (en[2]) p ^= r[22+i];
      if (en[3]) p ^= r[29+i];
      if (en[4]) p ^= r[36+i] ^ r[43+i];
      if (p) r[b] = ~r[b];
    end
    for (int i = 0; i < nD; i++) begin
      logic p;
      p = 1'b0;
      if (en[1]) p ^= r[20+i];
      if (en[2]) p ^= r[27+i];
      if (en[3]) p ^= r[34+i];
      if (en[4]) p ^= r[41+i];
      if (p) r[12+i] = ~r[12+i];
    end
    return {1'b0, r};
  endfunction

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one transaction: drive at negedge, sample 2ns after the capturing edge
  task automatic run(input string req, input logic [63:0] a, input logic [4:0] en,
                     input logic [5:0] cc, input logic [2:0] dc, input logic [2:0] sc,
                     input logic [5:0] pos);
    logic [64:0] exp;
    @(negedge clk);
    validIn = 1'b1; inAddr = a; hashEn = en; chanCount = cc;
    dieCount = dc; sockCount = sc; intlvPos = pos;
    exp = model(a, en, cc, dc, sc, pos);
    @(posedge clk);
    #2;
    chk(req, {outErr, outAddr}, exp);
    checks++;
    if (outValid !== 1'b1) begin
      errors++;
      $display("FAIL R10 outValid actual %b expected 1", outValid);
    end
  endtask

  task automatic runExp(input string req, input logic [63:0] a, input logic [4:0] en,
                        input logic [5:0] cc, input logic [2:0] dc, input logic [64:0] lit);
    @(negedge clk);
    validIn = 1'b1; inAddr = a; hashEn = en; chanCount = cc;
    dieCount = dc; sockCount = 3'd1; intlvPos = 6'd8;
    @(posedge clk);
    #2;
    chk(req, {outErr, outAddr}, lit);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset", {outErr, outAddr}, 65'd0);
    chk("R10 reset valid", {64'd0, outValid}, 65'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: channel 4 corrects position 14 (64K term bit 19), chan 32
    runExp("R1 jump to 14", 64'h1 << 19, 5'b00010, 6'd32, 3'd1, {1'b0, (64'h1 << 19) | (64'h1 << 14)});
    // R1: same with chan 16 leaves bit 14 alone
    runExp("R1 chan16 no bit4", 64'h1 << 19, 5'b00010, 6'd16, 3'd1, {1'b0, 64'h1 << 19});
    // R2: 4K term on channel 2 (bit 14 -> bit 10)
    runExp("R2 4K ch2", 64'h1 << 14, 5'b00001, 6'd8, 3'd1, {1'b0, (64'h1 << 14) | (64'h1 << 10)});
    // R2: 4K not on channel 3 (bit 15 stays, chan 16)
    runExp("R2 4K not ch3", 64'h1 << 15, 5'b00001, 6'd16, 3'd1, {1'b0, 64'h1 << 15});
    // R3: 2M term for channel 1
    runExp("R3 2M ch1", 64'h1 << 23, 5'b00100, 6'd8, 3'd1, {1'b0, (64'h1 << 23) | (64'h1 << 9)});
    // R3: 1G term for channel 0
    runExp("R3 1G ch0", 64'h1 << 29, 5'b01000, 6'd8, 3'd1, {1'b0, (64'h1 << 29) | (64'h1 << 8)});
    // R4: both 1T terms of channel 0 cancel
    runExp("R4 1T cancel", (64'h1 << 36) | (64'h1 << 43), 5'b10000, 6'd8, 3'd1, {1'b0, (64'h1 << 36) | (64'h1 << 43)});
    // R4: second 1T term alone flips channel 0
    runExp("R4 1T second", 64'h1 << 43, 5'b10000, 6'd8, 3'd1, {1'b0, (64'h1 << 43) | (64'h1 << 8)});
    // R5: die 1 with 1T term bit 42, die count 4
    runExp("R5 die1 1T", 64'h1 << 42, 5'b10000, 6'd8, 3'd4, {1'b0, (64'h1 << 42) | (64'h1 << 13)});
    // R5: die count 2 leaves die 1 alone
    runExp("R5 die cnt2", 64'h1 << 42, 5'b10000, 6'd8, 3'd2, {1'b0, 64'h1 << 42});
    // R6: die 0 flips bit 12 after channel 0 already read it
    runExp("R6 order", 64'h1 << 20, 5'b00011, 6'd8, 3'd2, {1'b0, (64'h1 << 20) | (64'h1 << 12)});
    // R6: channel 2 flips bit 10 using 4K bit 14, then channel 4 (base 14) via bit 19
    runExp("R6 running", (64'h1 << 14) | (64'h1 << 19), 5'b00011, 6'd32, 3'd1,
           {1'b0, (64'h1 << 19) | (64'h1 << 10)});
    // R7: no enables -> pass-through
    runExp("R7 no enable", 64'hFFFF_FFFF_FFFF_FFFF, 5'b00000, 6'd32, 3'd4, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF});
    // R8: bad position / die count / socket count
    run("R8 pos 9", 64'h0000_1234_5678_9ABC, 5'b11111, 6'd8, 3'd1, 3'd1, 6'd9);
    run("R8 die 5", 64'h0000_1234_5678_9ABC, 5'b11111, 6'd8, 3'd5, 3'd1, 6'd8);
    run("R8 die 0", 64'h0000_1234_5678_9ABC, 5'b11111, 6'd8, 3'd0, 3'd1, 6'd8);
    run("R8 socket 2", 64'h0000_1234_5678_9ABC, 5'b11111, 6'd8, 3'd1, 3'd2, 6'd8);
    // R9: bad channel counts
    run("R9 chan 4", 64'hDEAD_BEEF_CAFE_F00D, 5'b11111, 6'd4, 3'd1, 3'd1, 6'd8);
    run("R9 chan 24", 64'hDEAD_BEEF_CAFE_F00D, 5'b11111, 6'd24, 3'd1, 3'd1, 6'd8);

    // R10: idle cycle keeps result and drops valid
    begin
      logic [64:0] held;
      held = {outErr, outAddr};
      @(negedge clk);
      validIn = 1'b0; inAddr = ~inAddr;
      @(posedge clk);
      #2;
      chk("R10 hold", {outErr, outAddr}, held);
      chk("R10 valid low", {64'd0, outValid}, 65'd0);
    end

    // random mix, R1 R3 R5 R6 R7 R8 R9 against the model
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      logic [5:0] cc;
      logic [2:0] dc;
      logic [2:0] sc;
      logic [5:0] pos;
      int pick;
      a = {$urandom, $urandom};
      pick = $urandom % 10;
      cc = (pick < 3) ? 6'd8 : (pick < 6) ? 6'd16 : (pick < 9) ? 6'd32 : 6'($urandom);
      dc = ($urandom % 8 == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
      sc = ($urandom % 12 == 0) ? 3'($urandom) : 3'd1;
      pos = ($urandom % 12 == 0) ? 6'($urandom) : 6'd8;
      run("R6 random", a, 5'($urandom), cc, dc, sc, pos);
    end

    @(negedge clk);
    validIn = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule